// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Input Trigger Selection

This block collects up to 32 interrupt requests and presents one interrupt line to a 32-bit processor. A build-time mask marks each input as edge-sensitive or level-sensitive. Requests are latched into a status register. An enable register masks the status bits to give the pending set. The lowest-numbered pending source is reported as a vector number. The processor line is raised only while the master output enable is on.

Software controls the block over a simple word-addressed register bus with a 3-bit word offset and full 32-bit data. Writes take effect at the rising clock edge on which `bus_wr` is high. Reads are combinational from the current state.

Hardware capture is gated by a second master bit, the capture enable. While capture is off, inputs are not recorded, and software may write the status register directly to raise test interrupts. Once capture is on, direct writes to status are ignored. Enables are changed either by a plain write or through write-one-to-set and write-one-to-clear offsets. Status bits are cleared through a write-one-to-clear acknowledge offset.

Top module: `vec_intc`

## Requirements
- R1: After reset, status, enable, master control and the stored input history are all zero, the vector reads 0xFFFFFFFF, and `irq_out` is low.
- R2: Word offsets decode as follows: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. Reads of offsets 3, 4 and 5 return zero.
- R3: A level-sensitive input (its `EDGE_MASK` bit is 0) that is high at a clock edge while master bit 1 (capture enable) is set sets its status bit at that edge. This holds even when the same edge carries an acknowledge of that bit.
- R4: An edge-sensitive input (its `EDGE_MASK` bit is 1) sets its status bit only at the first edge after it goes from 0 to 1, and only while capture is enabled. The bit stays set after the input drops. An input held high is not captured again after an acknowledge. A rise that occurs while capture is off is not captured.
- R5: Pending always equals status AND enable, and it is visible in the same cycle as the state it is derived from.
- R6: The vector holds the index of the lowest-numbered pending bit, or 0xFFFFFFFF when nothing is pending.
- R7: `irq_out` is high exactly when master bit 0 (output enable) is set and at least one pending bit is set.
- R8: Writing the acknowledge offset clears every status bit written as 1 and leaves the other status bits unchanged.
- R9: Writing set-enable ORs the data into enable. Writing clear-enable clears every enable bit written as 1. Writing offset 2 replaces enable.
- R10: A write to master control stores only data bits 1:0. The other bits read back as zero.
- R11: A write to the status offset replaces status only while capture is disabled. While capture is enabled, such a write leaves status unchanged.
- R12: Writes to the pending and vector offsets have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | Interrupt request inputs, synchronous to `clk` |
| bus_wr | input | 1 | Write strobe for one full-word write |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk` and changes only between rising edges. They also assume that each `bus_wr` cycle carries exactly one well-formed full-word write. The bench drives the inputs and the write strobe only on falling edges, and it never issues more than one write per cycle. As a result, every capture and register update lands on a single, known rising edge. Edge-sensitive and level-sensitive inputs are exercised on different bits of a fixed mask, so each assertion sees both trigger kinds with capture both on and off.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int          NSRC      = 32,
  parameter int          DW        = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_out
);

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_PEND = 3'd1;
  localparam logic [2:0] A_EN   = 3'd2;
  localparam logic [2:0] A_ACK  = 3'd3;
  localparam logic [2:0] A_SET  = 3'd4;
  localparam logic [2:0] A_CLR  = 3'd5;
  localparam logic [2:0] A_VEC  = 3'd6;
  localparam logic [2:0] A_MCTL = 3'd7;
  localparam logic [NSRC-1:0] KIND = EDGE_MASK[NSRC-1:0];

  logic [NSRC-1:0] stat_q, stat_d, en_q, en_d, prev_q, pend;
  logic [NSRC-1:0] lvl_hi, edge_rise, wdat;
  logic [1:0]      mctl_q;
  logic [DW-1:0]   vec;

  assign wdat      = bus_wdata[NSRC-1:0];
  assign lvl_hi    = irq_in & ~KIND;
  assign edge_rise = irq_in & ~prev_q & KIND;
  assign pend      = stat_q & en_q;
  assign irq_out   = mctl_q[0] & (|pend);

  always_comb begin
    stat_d = stat_q;
    if (bus_wr && bus_addr == A_ACK) stat_d = stat_q & ~wdat;
    if (bus_wr && bus_addr == A_STAT && !mctl_q[1]) stat_d = wdat;
    if (mctl_q[1]) stat_d = stat_d | lvl_hi | edge_rise;
  end

  always_comb begin
    en_d = en_q;
    if (bus_wr) begin
      case (bus_addr)
        A_EN:    en_d = wdat;
        A_SET:   en_d = en_q | wdat;
        A_CLR:   en_d = en_q & ~wdat;
        default: en_d = en_q;
      endcase
    end
  end

  always_comb begin
    vec = '1;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) vec = DW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      prev_q <= '0;
      mctl_q <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      prev_q <= irq_in;
      if (bus_wr && bus_addr == A_MCTL) mctl_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata = DW'(stat_q);
      A_PEND:  bus_rdata = DW'(pend);
      A_EN:    bus_rdata = DW'(en_q);
      A_VEC:   bus_rdata = vec;
      A_MCTL:  bus_rdata = DW'(mctl_q);
      default: bus_rdata = '0;
    endcase
  end

  AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mctl_q[1] && |lvl_hi) |=> ((stat_q & $past(lvl_hi)) == $past(lvl_hi))); // R3

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mctl_q[1] && |edge_rise) |=> ((stat_q & $past(edge_rise)) == $past(edge_rise))); // R4

  AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mctl_q[1] && !(bus_wr && (bus_addr == A_STAT || bus_addr == A_ACK)))
    |=> (stat_q == $past(stat_q))); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ACK && !mctl_q[1])
    |=> ((stat_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R8

  AST_STATUS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && mctl_q[1])
    |=> (($past(stat_q) & ~stat_q) == '0)); // R11

  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & en_q) == '0 |-> (vec == '1)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mctl_q[0] && vec != '1)); // R7

endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
  localparam logic [31:0] EMASK = 32'h0000_FF00;

  typedef struct packed {
    logic        wr;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [31:0] irq;
    logic [2:0]  ra;
    logic [31:0] exp;
    logic        eirq;
    logic [3:0]  req;
  } row_t;

  localparam int NROW = 25;
  localparam row_t TBL [NROW] = '{
    {1'b0, 3'd0, 32'h0,          32'h0,    3'd6, 32'hFFFF_FFFF, 1'b0, 4'd1},  // R1 idle vector
    {1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0,    3'd7, 32'h3,         1'b0, 4'd10}, // R10 mask to 2 bits
    {1'b1, 3'd4, 32'h0000_0F10, 32'h0,    3'd2, 32'h0000_0F10, 1'b0, 4'd9},  // R9 set-enable
    {1'b1, 3'd5, 32'h0000_0010, 32'h0,    3'd2, 32'h0000_0F00, 1'b0, 4'd9},  // R9 clear-enable
    {1'b0, 3'd0, 32'h0,          32'h5,    3'd0, 32'h5,         1'b0, 4'd3},  // R3 level capture
    {1'b0, 3'd0, 32'h0,          32'h5,    3'd1, 32'h0,         1'b0, 4'd5},  // R5 masked off
    {1'b1, 3'd4, 32'h4,          32'h5,    3'd6, 32'd2,         1'b1, 4'd6},  // R6 vector 2
    {1'b1, 3'd3, 32'h5,          32'h5,    3'd0, 32'h5,         1'b1, 4'd3},  // R3 ack loses to held level
    {1'b0, 3'd0, 32'h0,          32'h0,    3'd0, 32'h5,         1'b1, 4'd3},  // R3 status sticky
    {1'b1, 3'd3, 32'h5,          32'h0,    3'd0, 32'h0,         1'b0, 4'd8},  // R8 ack clears
    {1'b0, 3'd0, 32'h0,          32'h100,  3'd0, 32'h100,       1'b1, 4'd4},  // R4 edge capture
    {1'b0, 3'd0, 32'h0,          32'h0,    3'd0, 32'h100,       1'b1, 4'd4},  // R4 stays after drop
    {1'b0, 3'd0, 32'h0,          32'h0,    3'd6, 32'd8,         1'b1, 4'd6},  // R6 vector 8
    {1'b0, 3'd0, 32'h0,          32'h100,  3'd0, 32'h100,       1'b1, 4'd4},  // R4 new rise
    {1'b1, 3'd3, 32'h100,        32'h100,  3'd0, 32'h0,         1'b0, 4'd4},  // R4 held high not recaptured
    {1'b1, 3'd0, 32'hFFFF_0000,  32'h0,    3'd0, 32'h0,         1'b0, 4'd11}, // R11 write locked
    {1'b1, 3'd7, 32'h1,          32'h0,    3'd7, 32'h1,         1'b0, 4'd10}, // R10 capture off
    {1'b1, 3'd0, 32'h0000_0A00,  32'h0,    3'd0, 32'h0000_0A00, 1'b1, 4'd11}, // R11 test write
    {1'b0, 3'd0, 32'h0,          32'h0,    3'd6, 32'd9,         1'b1, 4'd6},  // R6 vector 9
    {1'b0, 3'd0, 32'h0,          32'h1003, 3'd0, 32'h0000_0A00, 1'b1, 4'd4},  // R4 no capture when off
    {1'b1, 3'd1, 32'h0,          32'h1003, 3'd1, 32'h0000_0A00, 1'b1, 4'd12}, // R12 pending write
    {1'b1, 3'd6, 32'h5,          32'h1003, 3'd6, 32'd9,         1'b1, 4'd12}, // R12 vector write
    {1'b1, 3'd7, 32'h0,          32'h0,    3'd4, 32'h0,         1'b0, 4'd7},  // R7 output gated, R2
    {1'b0, 3'd0, 32'h0,          32'h0,    3'd5, 32'h0,         1'b0, 4'd2},  // R2 write-only offset
    {1'b1, 3'd5, 32'hFFFF_FFFF,  32'h0,    3'd1, 32'h0,         1'b0, 4'd5}   // R5 all disabled
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vec_intc #(.NSRC(32), .DW(32), .EDGE_MASK(EMASK)) u_vec_intc (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd(1, 3'd0, 32'h0);  // R1
    rd(1, 3'd2, 32'h0);  // R1
    rd(1, 3'd7, 32'h0);  // R1
    check(1, {31'h0, irq_out}, 32'h0);  // R1

    foreach (TBL[i]) begin
      @(negedge clk);
      bus_wr = TBL[i].wr; bus_addr = TBL[i].wa;
      bus_wdata = TBL[i].wd; irq_in = TBL[i].irq;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(int'(TBL[i].req), TBL[i].ra, TBL[i].exp);
      check(7, {31'h0, irq_out}, {31'h0, TBL[i].eirq});  // R7
    end

    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1);
    wr(3'd0, 32'h8000_0000);
    rd(6, 3'd6, 32'd31);  // R6 top source
    wr(3'd0, 32'h8000_0001);
    rd(6, 3'd6, 32'd0);   // R6 lowest wins
    check(7, {31'h0, irq_out}, 32'h1);  // R7

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd(1, 3'd0, 32'h0);           // R1
    rd(1, 3'd2, 32'h0);           // R1
    rd(1, 3'd6, 32'hFFFF_FFFF);   // R1
    check(1, {31'h0, irq_out}, 32'h0);  // R1

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule